// File: doc/BRIEF.md
# Four-Channel LED Controller Register Bank

This block is the register store of a four-output LED driver. A host reaches it over a byte-wide access port with an address, write data, a write strobe, a read strobe and registered read data. The block keeps the global enable, the per-output enables, the fade and exponential-dimming settings, the output-current range, and the per-output current and manual PWM bytes. It drives all of these as plain control outputs to the channel logic.

Three write-only addresses act as commands. Each fires only when one exact key byte is written to it, and the three commands are shutdown, soft reset and configuration commit. The configuration bytes at 0x01 to 0x04 are double-buffered. The host writes a staging copy and reads that staging copy back. The outputs follow a live copy, which takes the staged values only on commit. Two sticky status flags record a thermal event and a hardware reset release, and the host clears them by writing 1 to the matching bit.

The access port has no back-pressure: every strobe is taken in the cycle it is presented. Read data appears on the clock edge that samples the read strobe and holds until the next read.

Top module: `led_regblock`

## Requirements
- R1: While hardware reset is held, and after it is released, every control output is 0. In the first clock after release, the power-on flag (bit 0 of status address 0x40) sets, so a read of 0x40 returns 0x01.
- R2: Bit 0 of address 0x00 is the device enable. It reads back with bits 7..1 as 0, and `dev_en_o` follows it at once while the block is not shut down.
- R3: Writes to 0x01 (bit 0 current range), 0x02 (bits 3..0 output enables, output 0 in bit 0), 0x03 (bits 7..4 fade code, bits 3..0 fade enables) and 0x04 (bits 7..4 exponential enables) read back at once. The matching outputs change only in the cycle after 0x55 is written to 0x0F, and they then show the staged values.
- R4: Writing any value other than 0x55 to 0x0F leaves the configuration outputs unchanged.
- R5: Writing 0x33 to 0x0D raises `shutdown_o`, which forces `dev_en_o` low and stays high until a reset. Any other value written to 0x0D has no effect.
- R6: Writing 0xCC to 0x0E returns every register, the staging and live configuration, the flags and the shutdown state to 0. Any other value written to 0x0E has no effect.
- R7: Each flag is sticky. Bit 1 is the thermal flag, set by a one-cycle `tsd_evt_i` pulse, and bit 0 is the power-on flag. Writing 1 to bit 1 or bit 0 of 0x13 clears that flag. When a set and a clear arrive in the same cycle, the flag stays set.
- R8: Addresses 0x14..0x17 hold the current bytes and 0x18..0x1B hold the PWM duties for outputs 0..3. Each reads back, and each drives its byte lane of `dc_o` or `pwm_o` (output n in bits 8n+7..8n) from the next cycle on.
- R9: Addresses 0x0D, 0x0E, 0x0F, 0x13 and every unmapped address read as 0x00. Writes to an unmapped address change nothing.
- R10: `rd_data_o` takes the addressed value on the edge that samples `rd_en_i` and holds it while `rd_en_i` is low.
- R11: The reserved bits 7..4 of 0x02 and 3..0 of 0x04 read as 0 whatever is written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| tsd_evt_i | input | 1 | One-cycle thermal event pulse |
| dev_en_o | output | 1 | Device enable, low during shutdown |
| shutdown_o | output | 1 | Shutdown state |
| max_cur_o | output | 1 | Live current-range select |
| out_en_o | output | 4 | Live per-output enables |
| fade_en_o | output | 4 | Live per-output fade enables |
| fade_code_o | output | 4 | Live fade-time code |
| exp_en_o | output | 4 | Live per-output exponential enables |
| dc_o | output | 32 | Current bytes, output n in bits 8n+7..8n |
| pwm_o | output | 32 | PWM duties, output n in bits 8n+7..8n |
| flags_o | output | 2 | Sticky flags: bit 1 thermal, bit 0 power-on |

## Verification
The hardest case to reach is a flag clear arriving in the same cycle as a thermal event. That needs the write strobe to 0x13 and the event pulse to share one clock edge, so the bench drives both in the same negative-edge slot and then reads 0x40. The second hard case is the staged/live split. The bench writes the configuration bytes and first confirms the outputs are still 0 while readback shows the new values. It then writes a wrong key to 0x0F before the right one, and checks the outputs in the cycle after commit.

// File: rtl/led_reg_pkg.sv
package led_reg_pkg;
  localparam int DW  = 8;
  localparam int AW  = 8;
  localparam int NCH = 4;

  localparam logic [AW-1:0] A_CHIP    = 8'h00;
  localparam logic [AW-1:0] A_RANGE   = 8'h01;
  localparam logic [AW-1:0] A_OUTEN   = 8'h02;
  localparam logic [AW-1:0] A_FADE    = 8'h03;
  localparam logic [AW-1:0] A_EXPO    = 8'h04;
  localparam logic [AW-1:0] A_SHDN    = 8'h0D;
  localparam logic [AW-1:0] A_SRST    = 8'h0E;
  localparam logic [AW-1:0] A_COMMIT  = 8'h0F;
  localparam logic [AW-1:0] A_FLAGCLR = 8'h13;
  localparam logic [AW-1:0] A_DC0     = 8'h14;
  localparam logic [AW-1:0] A_PWM0    = 8'h18;
  localparam logic [AW-1:0] A_FLAGS   = 8'h40;

  localparam logic [DW-1:0] K_SHDN    = 8'h33;
  localparam logic [DW-1:0] K_SRST    = 8'hCC;
  localparam logic [DW-1:0] K_COMMIT  = 8'h55;

  typedef struct packed {
    logic           max_cur;
    logic [NCH-1:0] out_en;
    logic [3:0]     fade_code;
    logic [NCH-1:0] fade_en;
    logic [NCH-1:0] exp_en;
  } cfg_t;
endpackage

// File: rtl/led_cmd_decode.sv
module led_cmd_decode
  import led_reg_pkg::*;
(
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          shdn_p,
  output logic          srst_p,
  output logic          commit_p,
  output logic          flagclr_p
);
  always_comb begin
    shdn_p    = wr_en && (addr == A_SHDN)   && (wdata == K_SHDN);
    srst_p    = wr_en && (addr == A_SRST)   && (wdata == K_SRST);
    commit_p  = wr_en && (addr == A_COMMIT) && (wdata == K_COMMIT);
    flagclr_p = wr_en && (addr == A_FLAGCLR);
  end
endmodule

// File: rtl/led_cfg_bank.sv
module led_cfg_bank
  import led_reg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          commit,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output cfg_t          staged,
  output cfg_t          live
);
  cfg_t stg_q, live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else if (srst) begin
      stg_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_RANGE: stg_q.max_cur <= wdata[0];
        A_OUTEN: stg_q.out_en  <= wdata[NCH-1:0];
        A_FADE: begin
          stg_q.fade_code <= wdata[7:4];
          stg_q.fade_en   <= wdata[NCH-1:0];
        end
        A_EXPO:  stg_q.exp_en  <= wdata[7:8-NCH];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      live_q <= '0;
    else if (srst)   live_q <= '0;
    else if (commit) live_q <= stg_q;
  end

  assign staged = stg_q;
  assign live   = live_q;
endmodule

// File: rtl/led_flag_bank.sv
module led_flag_bank #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          clr_wr,
  input  logic [NF-1:0] clr_bits,
  input  logic [NF-1:0] set_evt,
  output logic [NF-1:0] flags
);
  logic [NF-1:0] flag_q;

  for (genvar f = 0; f < NF; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[f] <= 1'b0;
      else        flag_q[f] <= set_evt[f] |
                               (flag_q[f] & ~(srst | (clr_wr & clr_bits[f])));
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/led_chan_regs.sv
module led_chan_regs
  import led_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [NCH*DW-1:0] dc,
  output logic [NCH*DW-1:0] pwm
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] dc_q, pwm_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dc_q  <= '0;
        pwm_q <= '0;
      end else if (srst) begin
        dc_q  <= '0;
        pwm_q <= '0;
      end else if (wr_en) begin
        if (addr == A_DC0 + AW'(c))  dc_q  <= wdata;
        if (addr == A_PWM0 + AW'(c)) pwm_q <= wdata;
      end
    end
    assign dc[c*DW +: DW]  = dc_q;
    assign pwm[c*DW +: DW] = pwm_q;
  end
endmodule

// File: rtl/led_regblock.sv
module led_regblock
  import led_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              tsd_evt_i,
  output logic              dev_en_o,
  output logic              shutdown_o,
  output logic              max_cur_o,
  output logic [NCH-1:0]    out_en_o,
  output logic [NCH-1:0]    fade_en_o,
  output logic [3:0]        fade_code_o,
  output logic [NCH-1:0]    exp_en_o,
  output logic [NCH*DW-1:0] dc_o,
  output logic [NCH*DW-1:0] pwm_o,
  output logic [1:0]        flags_o
);
  logic shdn_p, srst_p, commit_p, flagclr_p;
  logic chip_en_q, shdn_q, por_pend_q;
  logic [DW-1:0] rd_q, rd_mux;
  cfg_t staged, live;

  led_cmd_decode u_dec (
    .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
    .shdn_p(shdn_p), .srst_p(srst_p), .commit_p(commit_p), .flagclr_p(flagclr_p)
  );

  led_cfg_bank u_cfg (
    .clk(clk), .rst_n(rst_n), .srst(srst_p), .commit(commit_p),
    .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
    .staged(staged), .live(live)
  );

  led_flag_bank #(.NF(2)) u_flags (
    .clk(clk), .rst_n(rst_n), .srst(srst_p), .clr_wr(flagclr_p),
    .clr_bits(wdata_i[1:0]), .set_evt({tsd_evt_i, por_pend_q}), .flags(flags_o)
  );

  led_chan_regs u_ch (
    .clk(clk), .rst_n(rst_n), .srst(srst_p), .wr_en(wr_en_i),
    .addr(addr_i), .wdata(wdata_i), .dc(dc_o), .pwm(pwm_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_en_q  <= 1'b0;
      shdn_q     <= 1'b0;
      por_pend_q <= 1'b1;
    end else begin
      por_pend_q <= 1'b0;
      if (srst_p) begin
        chip_en_q <= 1'b0;
        shdn_q    <= 1'b0;
      end else begin
        if (wr_en_i && addr_i == A_CHIP) chip_en_q <= wdata_i[0];
        if (shdn_p) shdn_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_CHIP:  rd_mux = {{(DW-1){1'b0}}, chip_en_q};
      A_RANGE: rd_mux = {{(DW-1){1'b0}}, staged.max_cur};
      A_OUTEN: rd_mux = {{(DW-NCH){1'b0}}, staged.out_en};
      A_FADE:  rd_mux = {staged.fade_code, staged.fade_en};
      A_EXPO:  rd_mux = {staged.exp_en, {(DW-NCH){1'b0}}};
      A_FLAGS: rd_mux = {{(DW-2){1'b0}}, flags_o};
      default: begin
        for (int c = 0; c < NCH; c++) begin
          if (addr_i == A_DC0 + AW'(c))  rd_mux = dc_o[c*DW +: DW];
          if (addr_i == A_PWM0 + AW'(c)) rd_mux = pwm_o[c*DW +: DW];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o   = rd_q;
  assign shutdown_o  = shdn_q;
  assign dev_en_o    = chip_en_q & ~shdn_q;
  assign max_cur_o   = live.max_cur;
  assign out_en_o    = live.out_en;
  assign fade_en_o   = live.fade_en;
  assign fade_code_o = live.fade_code;
  assign exp_en_o    = live.exp_en;
endmodule

// File: rtl/led_regblock_chk.sv
module led_regblock_chk
  import led_reg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [AW-1:0]     addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rd_data_o,
  input logic              tsd_evt_i,
  input logic              dev_en_o,
  input logic              shutdown_o,
  input logic              max_cur_o,
  input logic [NCH-1:0]    out_en_o,
  input logic [NCH-1:0]    fade_en_o,
  input logic [3:0]        fade_code_o,
  input logic [NCH-1:0]    exp_en_o,
  input logic [NCH*DW-1:0] dc_o,
  input logic [NCH*DW-1:0] pwm_o,
  input logic [1:0]        flags_o
);
  logic commit_w, srst_w;
  assign commit_w = wr_en_i && addr_i == A_COMMIT && wdata_i == K_COMMIT;
  assign srst_w   = wr_en_i && addr_i == A_SRST   && wdata_i == K_SRST;

  p_live_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_w && !srst_w) |=> ($stable(out_en_o) && $stable(fade_en_o) &&
      $stable(fade_code_o) && $stable(exp_en_o) && $stable(max_cur_o)));

  p_shdn_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_o && !srst_w) |=> shutdown_o);

  p_shdn_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |-> !dev_en_o);

  p_srst_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    srst_w |=> (!shutdown_o && out_en_o == '0 && dc_o == '0 && pwm_o == '0 &&
                !dev_en_o && flags_o[0] == 1'b0));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_evt_i |=> flags_o[1]);

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind led_regblock led_regblock_chk u_chk (.*);

// File: tb/sim_led_regblock.sv
`timescale 1ns/1ps
module sim_led_regblock;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, tsd = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic dev_en, shdn, max_cur;
  logic [3:0] out_en, fade_en, fade_code, exp_en;
  logic [31:0] dc, pwm;
  logic [1:0] flags;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  led_regblock u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rd_data_o(rdata), .tsd_evt_i(tsd),
    .dev_en_o(dev_en), .shutdown_o(shdn), .max_cur_o(max_cur),
    .out_en_o(out_en), .fade_en_o(fade_en), .fade_code_o(fade_code),
    .exp_en_o(exp_en), .dc_o(dc), .pwm_o(pwm), .flags_o(flags)
  );

  // columns: address, write data, expected readback, requirement number
  localparam logic [7:0] VEC [14][4] = '{
    '{8'h00, 8'hFF, 8'h01, 8'd2},   // R2 reserved bits drop
    '{8'h02, 8'hAF, 8'h0F, 8'd11},  // R11
    '{8'h03, 8'hA5, 8'hA5, 8'd3},   // R3 staged readback
    '{8'h04, 8'hFF, 8'hF0, 8'd11},  // R11
    '{8'h01, 8'hFF, 8'h01, 8'd3},
    '{8'h14, 8'h12, 8'h12, 8'd8},   // R8
    '{8'h17, 8'h9C, 8'h9C, 8'd8},
    '{8'h18, 8'h80, 8'h80, 8'd8},
    '{8'h1B, 8'hFF, 8'hFF, 8'd8},
    '{8'h0D, 8'h00, 8'h00, 8'd9},   // R9 command reads zero
    '{8'h0E, 8'h01, 8'h00, 8'd9},
    '{8'h0F, 8'h54, 8'h00, 8'd4},   // R4 wrong key
    '{8'h13, 8'h00, 8'h00, 8'd9},
    '{8'h20, 8'h77, 8'h00, 8'd9}    // unmapped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {dev_en, shdn, max_cur, out_en, dc[7:0], pwm[7:0]}, '0);
    rst_n = 1'b1;
    rd(8'h40, v); check("R1 power-on flag", v, 8'h01);
    check("R1 outputs after reset", {dev_en, shdn, out_en, fade_code}, '0);

    for (int i = 0; i < 14; i++) begin
      wr(VEC[i][0], VEC[i][1]);
      rd(VEC[i][0], v);
      check($sformatf("R%0d table row %0d", VEC[i][3], i), v, VEC[i][2]);
    end

    check("R8 current lanes", dc, 32'h9C00_0012);
    check("R8 pwm lanes", pwm, 32'hFF00_0080);
    check("R2 device enable", dev_en, 1'b1);
    check("R3 R4 live held before commit",
          {max_cur, out_en, fade_code, fade_en, exp_en}, '0);

    @(negedge clk); wr_en = 1'b1; addr = 8'h0F; wdata = 8'h55;
    @(negedge clk); wr_en = 1'b0;
    check("R3 live after commit", {max_cur, out_en, fade_code, fade_en, exp_en},
          {1'b1, 4'hF, 4'hA, 4'h5, 4'hF});

    // R7 sticky flags
    @(negedge clk); tsd = 1'b1; @(negedge clk); tsd = 1'b0;
    rd(8'h40, v); check("R7 both flags", v, 8'h03);
    wr(8'h13, 8'h01);
    rd(8'h40, v); check("R7 clear power-on", v, 8'h02);
    @(negedge clk); wr_en = 1'b1; addr = 8'h13; wdata = 8'h02; tsd = 1'b1;
    @(negedge clk); wr_en = 1'b0; tsd = 1'b0;
    rd(8'h40, v); check("R7 set wins", v, 8'h02);
    wr(8'h13, 8'h02);
    rd(8'h40, v); check("R7 clear thermal", v, 8'h00);

    // R5 shutdown
    wr(8'h0D, 8'h32);
    check("R5 wrong key", {shdn, dev_en}, 2'b01);
    wr(8'h0D, 8'h33);
    check("R5 shutdown", {shdn, dev_en}, 2'b10);
    wr(8'h0E, 8'h00);
    check("R6 wrong reset key", shdn, 1'b1);

    // R10 read hold
    rd(8'h14, v);
    repeat (3) @(negedge clk);
    check("R10 read hold", rdata, 8'h12);

    // R6 soft reset
    wr(8'h0E, 8'hCC);
    check("R6 outputs cleared", {shdn, dev_en, out_en, fade_code, dc, pwm}, '0);
    rd(8'h03, v); check("R6 staged cleared", v, 8'h00);
    rd(8'h14, v); check("R6 current cleared", v, 8'h00);
    rd(8'h40, v); check("R6 flags cleared", v, 8'h00);

    finish_run();
  end
endmodule